// File: doc/BRIEF.md
# External Bus Read Controller

This block runs single read cycles on an asynchronous parallel memory bus whose address space is split into zones, each with its own active-low select line. A host hands over a zone number and an address. The block lowers that zone's select and holds it through a lead phase. It then lowers an active-low read strobe for an active phase. The active phase can be stretched by a ready input from the external device. When the strobe rises, the block captures the data bus. An optional trail phase follows with the select still low. The block then raises the select and returns the captured word to the host with a one-cycle completion pulse.

Lead, active and trail lengths are counted in periods of the block clock and are set per zone. Each zone can also enable or ignore the ready input, and can take ready either straight off the pin (synchronous mode) or through a multi-flop synchronizer (asynchronous mode). Between accesses the address bus keeps the last address that was driven, but bit 0 is forced high. While an access is running, the block raises `busy` and ignores any new request.

Top module: `xbus_rd_ctrl`

## Requirements
- R1: After reset, every zone select and the read strobe are high, `busy` and `done` are low, `rd_data` is zero, and `bus_addr` is all zeros except bit 0, which is 1.
- R2: A request accepted at a clock edge drives low only the select bit whose index equals `req_zone`, from the next cycle on. The strobe stays high for the first lead-count cycles of the access.
- R3: When ready checking is off for the zone (`cfg_rdy_en` bit = 0), the strobe stays low for exactly the active count of cycles, whatever `bus_ready` does.
- R4: In synchronous mode (`cfg_rdy_async` bit = 0), ready is first sampled at the edge that ends the active-count-th strobe cycle, and again at every later edge. The strobe rises at the first such edge where `bus_ready` is high.
- R5: In asynchronous mode (`cfg_rdy_async` bit = 1), ready passes through SYNC_STAGES flops before it is sampled. With the default of 2, a ready that rises during strobe cycle n ends the strobe after cycle n+2 at the earliest.
- R6: Read data is captured at the edge where the strobe rises. Changes on `bus_data_in` after that edge do not alter `rd_data`.
- R7: After the strobe rises, the select stays low for the trail count of cycles (0 allowed) and then rises. `done` is high for exactly one cycle, the first cycle with all selects high, and `rd_data` then holds the captured word.
- R8: While a select is low, `bus_addr` equals the requested address.
- R9: When no access is running, `bus_addr` holds the last requested address with bit 0 forced to 1.
- R10: `busy` is high from the cycle after acceptance until the cycle before `done`. A request made while `busy` is high is dropped and starts no access.
- R11: A lead or active count of 0 acts as 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; one period is one timing unit |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Host read request, taken when not busy |
| req_zone | input | ZONE_W | Zone of the request |
| req_addr | input | ADDR_W | Address of the request |
| cfg_lead | input | ZONES*CNT_W | Per-zone lead count, zone z at bits z*CNT_W upward |
| cfg_active | input | ZONES*CNT_W | Per-zone active count, same packing |
| cfg_trail | input | ZONES*CNT_W | Per-zone trail count, same packing |
| cfg_rdy_en | input | ZONES | Per-zone ready checking enable |
| cfg_rdy_async | input | ZONES | Per-zone asynchronous ready mode |
| bus_ready | input | 1 | Ready from the external device |
| bus_data_in | input | DATA_W | External data bus |
| busy | output | 1 | Access in progress |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | DATA_W | Captured read word |
| bus_cs_n | output | ZONES | Active-low zone selects |
| bus_rd_n | output | 1 | Active-low read strobe |
| bus_addr | output | ADDR_W | External address bus |

## Verification
The assertions check the following on every cycle:
- the strobe is never low without a select;
- at most one select is low;
- the strobe falls only after a select has been low for a cycle;
- the address is steady while a select is held, and steady with bit 0 high while idle;
- a select is never low without `busy`;
- `done` is a single pulse that comes right after the select rises.

The cycle counts of each phase, the effect of the ready sampling modes and synchronizer latency, data capture at the strobe edge, and the dropping of a request made while busy depend on the stimulus. Only the bench's scenarios show these.

// File: rtl/xbus_rd_pkg.sv
package xbus_rd_pkg;

   typedef enum logic [1:0] {
      PH_IDLE   = 2'd0,
      PH_LEAD   = 2'd1,
      PH_ACTIVE = 2'd2,
      PH_TRAIL  = 2'd3
   } rd_phase_e;

endpackage

// File: rtl/xbus_rdy_sync.sv
module xbus_rdy_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic rdy_in,
   output logic rdy_out
);

   logic [STAGES-1:0] chain_q;

   generate
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain_q[0] <= 1'b0;
               else        chain_q[0] <= rdy_in;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain_q[s] <= 1'b0;
               else        chain_q[s] <= chain_q[s-1];
            end
         end
      end
   endgenerate

   assign rdy_out = chain_q[STAGES-1];

endmodule

// File: rtl/xbus_rd_fsm.sv
module xbus_rd_fsm
   import xbus_rd_pkg::*;
#(
   parameter int ZONES  = 4,
   parameter int ZONE_W = 2,
   parameter int CNT_W  = 4
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   req_valid,
   input  logic [ZONE_W-1:0]      req_zone,
   input  logic [ZONES*CNT_W-1:0] cfg_lead,
   input  logic [ZONES*CNT_W-1:0] cfg_active,
   input  logic [ZONES*CNT_W-1:0] cfg_trail,
   input  logic [ZONES-1:0]       cfg_rdy_en,
   input  logic [ZONES-1:0]       cfg_rdy_async,
   input  logic                   rdy_direct,
   input  logic                   rdy_synced,
   output rd_phase_e              phase,
   output logic [ZONE_W-1:0]      zone_q,
   output logic                   accept,
   output logic                   capture,
   output logic                   done
);

   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   logic [CNT_W-1:0] lead_arr  [ZONES];
   logic [CNT_W-1:0] act_arr   [ZONES];
   logic [CNT_W-1:0] trail_arr [ZONES];

   generate
      for (genvar z = 0; z < ZONES; z++) begin : g_unpack
         assign lead_arr[z]  = cfg_lead[z*CNT_W +: CNT_W];
         assign act_arr[z]   = cfg_active[z*CNT_W +: CNT_W];
         assign trail_arr[z] = cfg_trail[z*CNT_W +: CNT_W];
      end
   endgenerate

   function automatic logic [CNT_W-1:0] at_least_one(input logic [CNT_W-1:0] v);
      return (v == '0) ? ONE : v;
   endfunction

   rd_phase_e        phase_q;
   logic [CNT_W-1:0] cnt_q, lead_q, act_q, trail_q;
   logic             rdy_en_q, async_q, done_q;
   logic             rdy_pick, act_spent;

   assign rdy_pick  = async_q ? rdy_synced : rdy_direct;
   assign act_spent = (cnt_q >= act_q - ONE);
   assign accept    = (phase_q == PH_IDLE) && req_valid;
   assign capture   = (phase_q == PH_ACTIVE) && act_spent && (!rdy_en_q || rdy_pick);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q  <= PH_IDLE;
         cnt_q    <= '0;
         lead_q   <= ONE;
         act_q    <= ONE;
         trail_q  <= '0;
         rdy_en_q <= 1'b0;
         async_q  <= 1'b0;
         zone_q   <= '0;
         done_q   <= 1'b0;
      end else begin
         done_q <= 1'b0;
         unique case (phase_q)
            PH_IDLE: begin
               if (req_valid) begin
                  phase_q  <= PH_LEAD;
                  cnt_q    <= '0;
                  zone_q   <= req_zone;
                  lead_q   <= at_least_one(lead_arr[req_zone]);
                  act_q    <= at_least_one(act_arr[req_zone]);
                  trail_q  <= trail_arr[req_zone];
                  rdy_en_q <= cfg_rdy_en[req_zone];
                  async_q  <= cfg_rdy_async[req_zone];
               end
            end
            PH_LEAD: begin
               if (cnt_q >= lead_q - ONE) begin
                  phase_q <= PH_ACTIVE;
                  cnt_q   <= '0;
               end else begin
                  cnt_q <= cnt_q + ONE;
               end
            end
            PH_ACTIVE: begin
               if (!act_spent) begin
                  cnt_q <= cnt_q + ONE;
               end else if (capture) begin
                  cnt_q <= '0;
                  if (trail_q == '0) begin
                     phase_q <= PH_IDLE;
                     done_q  <= 1'b1;
                  end else begin
                     phase_q <= PH_TRAIL;
                  end
               end
            end
            PH_TRAIL: begin
               if (cnt_q >= trail_q - ONE) begin
                  phase_q <= PH_IDLE;
                  cnt_q   <= '0;
                  done_q  <= 1'b1;
               end else begin
                  cnt_q <= cnt_q + ONE;
               end
            end
            default: phase_q <= PH_IDLE;
         endcase
      end
   end

   assign phase = phase_q;
   assign done  = done_q;

endmodule

// File: rtl/xbus_rd_dpath.sv
module xbus_rd_dpath
   import xbus_rd_pkg::*;
#(
   parameter int ZONES  = 4,
   parameter int ZONE_W = 2,
   parameter int ADDR_W = 8,
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              accept,
   input  logic [ADDR_W-1:0] req_addr,
   input  rd_phase_e         phase,
   input  logic [ZONE_W-1:0] zone_q,
   input  logic              capture,
   input  logic [DATA_W-1:0] bus_data_in,
   output logic [ZONES-1:0]  bus_cs_n,
   output logic              bus_rd_n,
   output logic [ADDR_W-1:0] bus_addr,
   output logic [DATA_W-1:0] rd_data
);

   logic [ADDR_W-1:0] addr_q;
   logic [DATA_W-1:0] data_q;
   logic              in_access;

   assign in_access = (phase != PH_IDLE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_q <= '0;
         data_q <= '0;
      end else begin
         if (accept)  addr_q <= req_addr;
         if (capture) data_q <= bus_data_in;
      end
   end

   generate
      for (genvar z = 0; z < ZONES; z++) begin : g_sel
         assign bus_cs_n[z] = !(in_access && (zone_q == ZONE_W'(z)));
      end
   endgenerate

   assign bus_rd_n = (phase != PH_ACTIVE);
   assign bus_addr = in_access ? addr_q : {addr_q[ADDR_W-1:1], 1'b1};
   assign rd_data  = data_q;

endmodule

// File: rtl/xbus_rd_ctrl.sv
module xbus_rd_ctrl
   import xbus_rd_pkg::*;
#(
   parameter int ZONES       = 4,
   parameter int ADDR_W      = 8,
   parameter int DATA_W      = 16,
   parameter int CNT_W       = 4,
   parameter int SYNC_STAGES = 2,
   localparam int ZONE_W     = (ZONES > 1) ? $clog2(ZONES) : 1
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   req_valid,
   input  logic [ZONE_W-1:0]      req_zone,
   input  logic [ADDR_W-1:0]      req_addr,
   input  logic [ZONES*CNT_W-1:0] cfg_lead,
   input  logic [ZONES*CNT_W-1:0] cfg_active,
   input  logic [ZONES*CNT_W-1:0] cfg_trail,
   input  logic [ZONES-1:0]       cfg_rdy_en,
   input  logic [ZONES-1:0]       cfg_rdy_async,
   input  logic                   bus_ready,
   input  logic [DATA_W-1:0]      bus_data_in,
   output logic                   busy,
   output logic                   done,
   output logic [DATA_W-1:0]      rd_data,
   output logic [ZONES-1:0]       bus_cs_n,
   output logic                   bus_rd_n,
   output logic [ADDR_W-1:0]      bus_addr
);

   generate
      if (ZONES < 2)       begin : g_bad_zones $error("ZONES must be at least 2"); end
      if (ADDR_W < 2)      begin : g_bad_addr  $error("ADDR_W must be at least 2"); end
      if (CNT_W < 2)       begin : g_bad_cnt   $error("CNT_W must be at least 2"); end
      if (SYNC_STAGES < 2) begin : g_bad_sync  $error("SYNC_STAGES must be at least 2"); end
   endgenerate

   rd_phase_e         phase;
   logic [ZONE_W-1:0] zone_q;
   logic              accept, capture, rdy_synced;

   xbus_rdy_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .rdy_in  (bus_ready),
      .rdy_out (rdy_synced)
   );

   xbus_rd_fsm #(.ZONES(ZONES), .ZONE_W(ZONE_W), .CNT_W(CNT_W)) u_fsm (
      .clk           (clk),
      .rst_n         (rst_n),
      .req_valid     (req_valid),
      .req_zone      (req_zone),
      .cfg_lead      (cfg_lead),
      .cfg_active    (cfg_active),
      .cfg_trail     (cfg_trail),
      .cfg_rdy_en    (cfg_rdy_en),
      .cfg_rdy_async (cfg_rdy_async),
      .rdy_direct    (bus_ready),
      .rdy_synced    (rdy_synced),
      .phase         (phase),
      .zone_q        (zone_q),
      .accept        (accept),
      .capture       (capture),
      .done          (done)
   );

   xbus_rd_dpath #(.ZONES(ZONES), .ZONE_W(ZONE_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dpath (
      .clk         (clk),
      .rst_n       (rst_n),
      .accept      (accept),
      .req_addr    (req_addr),
      .phase       (phase),
      .zone_q      (zone_q),
      .capture     (capture),
      .bus_data_in (bus_data_in),
      .bus_cs_n    (bus_cs_n),
      .bus_rd_n    (bus_rd_n),
      .bus_addr    (bus_addr),
      .rd_data     (rd_data)
   );

   assign busy = (phase != PH_IDLE);

endmodule

// File: rtl/xbus_rd_chk.sv
module xbus_rd_chk #(
   parameter int ZONES  = 4,
   parameter int ADDR_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ZONES-1:0]  cs_n,
   input logic              rd_n,
   input logic [ADDR_W-1:0] bus_addr,
   input logic              busy,
   input logic              done
);

   localparam logic [ZONES-1:0] ALL_HI = {ZONES{1'b1}};

   AST_STROBE_NEEDS_SEL: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_n |-> (cs_n != ALL_HI)); // R2
   AST_ONE_SEL: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(~cs_n)); // R2
   AST_STROBE_AFTER_LEAD: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(rd_n) |-> ($past(cs_n) != ALL_HI)); // R2
   AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      ((cs_n != ALL_HI) && (cs_n == $past(cs_n))) |-> $stable(bus_addr)); // R8
   AST_IDLE_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !$past(busy)) |-> $stable(bus_addr)); // R9
   AST_IDLE_BIT0: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> bus_addr[0]); // R9
   AST_SEL_NEEDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      (cs_n != ALL_HI) |-> busy); // R10
   AST_DONE_AFTER_SEL: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> ((cs_n == ALL_HI) && ($past(cs_n) != ALL_HI))); // R7
   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done); // R7

endmodule

bind xbus_rd_ctrl xbus_rd_chk #(.ZONES(ZONES), .ADDR_W(ADDR_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .cs_n     (bus_cs_n),
   .rd_n     (bus_rd_n),
   .bus_addr (bus_addr),
   .busy     (busy),
   .done     (done)
);

// File: tb/tb_xbus_rd_ctrl.sv
module tb_xbus_rd_ctrl;

   localparam int ZONES = 4, ADDR_W = 8, DATA_W = 16, CNT_W = 4;

   typedef struct packed {
      logic [1:0]  zone;
      logic [7:0]  addr;
      logic [3:0]  lead;
      logic [3:0]  act;
      logic [3:0]  trail;
      logic        en;
      logic        asy;
      logic [3:0]  rdy_at;
      logic [15:0] data;
   } vec_t;

   localparam int NV = 8;
   localparam vec_t VECS [NV] = '{
      '{2'd0, 8'hA4, 4'd2, 4'd3, 4'd1, 1'b0, 1'b0, 4'd9, 16'h1234},
      '{2'd1, 8'h3B, 4'd1, 4'd2, 4'd0, 1'b1, 1'b0, 4'd0, 16'hBEEF},
      '{2'd2, 8'h5C, 4'd3, 4'd2, 4'd2, 1'b1, 1'b0, 4'd5, 16'h0F0F},
      '{2'd3, 8'h81, 4'd1, 4'd4, 4'd1, 1'b1, 1'b0, 4'd2, 16'hA5A5},
      '{2'd0, 8'h7E, 4'd2, 4'd2, 4'd1, 1'b1, 1'b1, 4'd3, 16'h5A5A},
      '{2'd1, 8'hC6, 4'd1, 4'd1, 4'd3, 1'b1, 1'b1, 4'd0, 16'hC0DE},
      '{2'd2, 8'h11, 4'd0, 4'd0, 4'd0, 1'b0, 1'b0, 4'd0, 16'h7777},
      '{2'd3, 8'hFF, 4'd4, 4'd3, 4'd2, 1'b1, 1'b1, 4'd1, 16'h9ABC}
   };

   logic                   clk = 1'b0, rst_n = 1'b0;
   logic                   req_valid = 1'b0;
   logic [1:0]             req_zone = '0;
   logic [ADDR_W-1:0]      req_addr = '0;
   logic [ZONES*CNT_W-1:0] cfg_lead = '0, cfg_active = '0, cfg_trail = '0;
   logic [ZONES-1:0]       cfg_rdy_en = '0, cfg_rdy_async = '0;
   logic                   bus_ready = 1'b0;
   logic [DATA_W-1:0]      bus_data_in = '0;
   logic                   busy, done, bus_rd_n;
   logic [DATA_W-1:0]      rd_data;
   logic [ZONES-1:0]       bus_cs_n;
   logic [ADDR_W-1:0]      bus_addr;

   int  checks = 0, errors = 0;
   bit  finished = 1'b0;

   always #10 clk = ~clk;

   xbus_rd_ctrl #(.ZONES(ZONES), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_zone(req_zone),
      .req_addr(req_addr), .cfg_lead(cfg_lead), .cfg_active(cfg_active),
      .cfg_trail(cfg_trail), .cfg_rdy_en(cfg_rdy_en), .cfg_rdy_async(cfg_rdy_async),
      .bus_ready(bus_ready), .bus_data_in(bus_data_in), .busy(busy), .done(done),
      .rd_data(rd_data), .bus_cs_n(bus_cs_n), .bus_rd_n(bus_rd_n), .bus_addr(bus_addr)
   );

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic int eff(input logic [3:0] v);
      return (v == 0) ? 1 : int'(v);
   endfunction

   function automatic int exp_rd(input vec_t v);
      int a = eff(v.act);
      int r;
      if (!v.en || v.rdy_at == 0) return a;
      r = int'(v.rdy_at) + (v.asy ? 2 : 0);
      return (r > a) ? r : a;
   endfunction

   task automatic program_zone(input vec_t v);
      cfg_lead[v.zone*CNT_W +: CNT_W]   = v.lead;
      cfg_active[v.zone*CNT_W +: CNT_W] = v.act;
      cfg_trail[v.zone*CNT_W +: CNT_W]  = v.trail;
      cfg_rdy_en[v.zone]    = v.en;
      cfg_rdy_async[v.zone] = v.asy;
   endtask

   task automatic run_read(input vec_t v);
      int n_lead = 0, n_rd = 0, n_trail = 0, guard = 0;
      bit seen_rd = 0, bad_cs = 0, bad_addr = 0, bad_busy = 0;
      logic [ZONES-1:0] exp_cs;
      exp_cs = ~(ZONES'(1) << v.zone);
      @(negedge clk);
      program_zone(v);
      bus_ready   = (v.rdy_at == 0);
      bus_data_in = v.data;
      req_valid = 1'b1; req_zone = v.zone; req_addr = v.addr;
      @(negedge clk);
      req_valid = 1'b0;
      while (bus_cs_n != '1 && guard < 200) begin
         if (bus_cs_n != exp_cs) bad_cs = 1;
         if (bus_addr != v.addr) bad_addr = 1;
         if (!busy) bad_busy = 1;
         if (!bus_rd_n) begin
            n_rd++; seen_rd = 1;
            if (n_rd >= int'(v.rdy_at)) bus_ready = 1'b1;
         end else if (!seen_rd) begin
            n_lead++;
         end else begin
            n_trail++;
            bus_data_in = ~v.data;   // R6: bus changes after strobe rise
         end
         @(negedge clk); guard++;
      end
      chk(!bad_cs, "R2 zone select", 0, exp_cs);
      chk(n_lead == eff(v.lead), "R2/R11 lead cycles", n_lead, eff(v.lead));
      chk(n_rd == exp_rd(v), v.en ? (v.asy ? "R5 strobe cycles async" : "R4 strobe cycles sync")
                                  : "R3 strobe cycles ready ignored", n_rd, exp_rd(v));
      chk(n_trail == int'(v.trail), "R7 trail cycles", n_trail, v.trail);
      chk(!bad_addr, "R8 address held", 0, v.addr);
      chk(!bad_busy, "R10 busy during access", 0, 1);
      chk(done === 1'b1, "R7 done pulse", done, 1);
      chk(rd_data === v.data, "R6 captured data", rd_data, v.data);
      chk(bus_addr === {v.addr[7:1], 1'b1}, "R9 idle address", bus_addr, {v.addr[7:1], 1'b1});
      bus_data_in = ~v.data;
      @(negedge clk);
      chk(done === 1'b0, "R7 done one cycle", done, 0);
      chk(rd_data === v.data, "R6 data kept", rd_data, v.data);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         checks++; errors++;
         $display("FAIL watchdog expired actual=%0h expected=%0h", 0, 1);
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1 reset state
      chk(bus_cs_n === '1, "R1 selects high", bus_cs_n, 4'hF);
      chk(bus_rd_n === 1'b1, "R1 strobe high", bus_rd_n, 1);
      chk(busy === 1'b0 && done === 1'b0, "R1 busy/done low", {busy, done}, 0);
      chk(bus_addr === 8'h01, "R1 idle address", bus_addr, 8'h01);
      chk(rd_data === '0, "R1 data zero", rd_data, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(bus_addr === 8'h01 && busy === 1'b0, "R1 after release", bus_addr, 8'h01);

      for (int i = 0; i < NV; i++) run_read(VECS[i]);

      // R10: request while busy is dropped
      begin
         vec_t v;
         int guard = 0;
         v = '{2'd1, 8'h62, 4'd5, 4'd2, 4'd1, 1'b0, 1'b0, 4'd0, 16'h4321};
         @(negedge clk);
         program_zone(v);
         bus_data_in = v.data;
         req_valid = 1'b1; req_zone = v.zone; req_addr = v.addr;
         @(negedge clk);
         req_valid = 1'b1; req_zone = 2'd2; req_addr = 8'h55;
         chk(busy === 1'b1, "R10 busy high", busy, 1);
         @(negedge clk);
         req_valid = 1'b0;
         chk(bus_cs_n === 4'b1101 && bus_addr === v.addr, "R10 second request ignored",
             {bus_cs_n, bus_addr}, {4'b1101, v.addr});
         while (!done && guard < 200) begin @(negedge clk); guard++; end
         chk(rd_data === v.data, "R10 first read data", rd_data, v.data);
         for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            chk(bus_cs_n === '1 && !done && !busy, "R10 no queued access",
                {bus_cs_n, done, busy}, {4'hF, 2'b00});
         end
         chk(bus_addr === 8'h63, "R9 idle address after drop", bus_addr, 8'h63);
      end

      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule